// File: doc/BRIEF.md
# Accumulate and Dump Unit

This block sums a stream of signed samples. Each cycle in which the accumulate strobe is high, the sample on the data input is sign-extended and added to an internal running total, and a sample count goes up by one. A separate dump strobe takes a snapshot of the total, publishes it on the result output with a one-cycle valid pulse, and restarts both the total and the count from zero. The unit is meant to sit behind a sample source whose strobes are single-cycle enables in the system clock domain, for example to integrate a demodulator output over a symbol period.

Two parameters pick the variant. `DUMP_FIRST` decides what happens when both strobes are high in the same cycle. With it set, the snapshot excludes the coincident sample, which becomes the first term of the next total (count 1). With it clear, the sample is added in before the snapshot and the next total starts empty. `AVERAGE` replaces the sum by the mean: the snapshot is passed to a sequential signed divider, which divides the total by the sample count, truncating toward zero. The divider is a three-state machine. `DIV_IDLE` waits for a snapshot. From there, a snapshot with a count of zero publishes zero at once and stays in `DIV_IDLE`, and a non-zero count loads the magnitude and moves to `DIV_STEP`. `DIV_STEP` produces one quotient bit per cycle for 2·DATA_W cycles and then moves to `DIV_SIGN`. `DIV_SIGN` applies the sign, publishes the result and returns to `DIV_IDLE`.

Top module: `accum_dump`

## Requirements
- R1: Each cycle with `acc_en` high and `dump_en` low adds the sign-extended `sample_in` (two's complement, DATA_W bits) to the running total and raises the sample count by one.
- R2: In sum mode (`AVERAGE`=0), the result and a high `result_vld` appear in the cycle right after the clock edge that samples `dump_en`. `result` holds the two's complement total of the samples collected since the previous dump.
- R3: After a dump without a coincident sample, the total and the count both restart at zero, so the next dumped value contains no earlier sample.
- R4: With `DUMP_FIRST`=1 and both strobes high together, the dumped value excludes that cycle's sample. The sample becomes the first term (count 1) of the following total.
- R5: With `DUMP_FIRST`=0 and both strobes high together, the dumped value includes that cycle's sample, and the following total starts from zero.
- R6: In averaging mode (`AVERAGE`=1), the result is the signed total divided by the sample count, truncated toward zero. It appears at most 2·DATA_W+2 cycles after the edge that samples `dump_en`.
- R7: A dump with no samples collected gives a result of zero in both modes, and no division is attempted.
- R8: The total is 2·DATA_W bits wide and is exact for 2^DATA_W samples of either extreme input value.
- R9: Every dump yields exactly one `result_vld` pulse, one cycle long.
- R10: A synchronous `rst` clears the total, the count, `result` and `result_vld`. A dump right after reset gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | DATA_W | Signed sample to accumulate |
| acc_en | input | 1 | Accumulate strobe, one cycle per sample |
| dump_en | input | 1 | Dump strobe, one cycle per result |
| result | output | 2*DATA_W | Dumped sum or mean, two's complement; holds until the next result |
| result_vld | output | 1 | One-cycle pulse marking a new result |

## Verification
The assertions assume one thing about the inputs: in averaging mode, no new dump reaches the divider while it is still in `DIV_STEP` or `DIV_SIGN`. Consecutive dumps must therefore be at least 2·DATA_W+2 cycles apart. Sum mode has no such limit. The stimulus keeps this spacing by following every dump with an idle window longer than the divider latency. It drives the same strobe pattern into all four parameter combinations at once. With a 4-bit sample, it sweeps every input value, group sizes from zero to five, coincident and separate strobes, full-length runs at both extreme values, and a reset in the middle of a group.

// File: rtl/accd_pkg.sv
`timescale 1ns/1ps
package accd_pkg;

    // Sequencing of the mean divider
    typedef enum logic [1:0] {
        DIV_IDLE = 2'd0,
        DIV_STEP = 2'd1,
        DIV_SIGN = 2'd2
    } div_state_e;

endpackage

// File: rtl/accd_core.sv
`timescale 1ns/1ps
module accd_core #(
    parameter int DATA_W     = 8,
    parameter bit DUMP_FIRST = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DATA_W-1:0]     sample_in,
    input  logic                  acc_en,
    input  logic                  dump_en,
    output logic [2*DATA_W-1:0]   snap_sum,
    output logic [DATA_W:0]       snap_cnt,
    output logic                  snap_vld
);
    localparam int ACC_W = 2 * DATA_W;
    localparam int CNT_W = DATA_W + 1;

    logic [ACC_W-1:0] acc_q, acc_d, samp_ext, add_sum;
    logic [CNT_W-1:0] cnt_q, cnt_d, add_cnt;
    logic [ACC_W-1:0] snap_sum_d, both_snap_sum, both_acc;
    logic [CNT_W-1:0] snap_cnt_d, both_snap_cnt, both_cnt;

    assign samp_ext = {{(ACC_W-DATA_W){sample_in[DATA_W-1]}}, sample_in};
    assign add_sum  = acc_q + samp_ext;
    assign add_cnt  = cnt_q + CNT_W'(1);

    // Coincident strobes: the parameter picks which comes first
    generate
        if (DUMP_FIRST) begin : g_dump_first
            assign both_snap_sum = acc_q;
            assign both_snap_cnt = cnt_q;
            assign both_acc      = samp_ext;
            assign both_cnt      = CNT_W'(1);
        end else begin : g_acc_first
            assign both_snap_sum = add_sum;
            assign both_snap_cnt = add_cnt;
            assign both_acc      = '0;
            assign both_cnt      = '0;
        end
    endgenerate

    always_comb begin
        acc_d      = acc_q;
        cnt_d      = cnt_q;
        snap_sum_d = acc_q;
        snap_cnt_d = cnt_q;
        unique case ({dump_en, acc_en})
            2'b01: begin
                acc_d = add_sum;
                cnt_d = add_cnt;
            end
            2'b10: begin
                acc_d = '0;
                cnt_d = '0;
            end
            2'b11: begin
                acc_d      = both_acc;
                cnt_d      = both_cnt;
                snap_sum_d = both_snap_sum;
                snap_cnt_d = both_snap_cnt;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            snap_sum <= '0;
            snap_cnt <= '0;
            snap_vld <= 1'b0;
        end else begin
            acc_q    <= acc_d;
            cnt_q    <= cnt_d;
            snap_vld <= dump_en;
            if (dump_en) begin
                snap_sum <= snap_sum_d;
                snap_cnt <= snap_cnt_d;
            end
        end
    end

    // R1: a lone accumulate strobe adds the sample and counts it
    p_acc_step_r1: assert property (@(posedge clk) disable iff (rst)
        acc_en && !dump_en |=> (cnt_q == $past(cnt_q) + CNT_W'(1))
                            && (acc_q == $past(acc_q) + $past(samp_ext)));

    // R3: total and count restart from zero after a plain dump
    p_clear_after_dump_r3: assert property (@(posedge clk) disable iff (rst)
        dump_en && !(acc_en && DUMP_FIRST) |=> acc_q == '0 && cnt_q == '0);

    // R4: dump-first keeps the coincident sample for the next total
    p_dump_first_r4: assert property (@(posedge clk) disable iff (rst)
        DUMP_FIRST && dump_en && acc_en |=> cnt_q == CNT_W'(1)
                                         && snap_sum == $past(acc_q));

    // R5: accumulate-first folds the coincident sample into the snapshot
    p_acc_first_r5: assert property (@(posedge clk) disable iff (rst)
        !DUMP_FIRST && dump_en && acc_en |=>
            snap_sum == $past(acc_q) + $past(samp_ext) && acc_q == '0);

endmodule

// File: rtl/accd_divider.sv
`timescale 1ns/1ps
module accd_divider
    import accd_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ACC_W-1:0] sum_in,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [ACC_W-1:0] quot_out,
    output logic             quot_vld
);
    localparam int STEP_W = (ACC_W > 1) ? $clog2(ACC_W) : 1;

    div_state_e        state_q, state_d;
    logic [ACC_W-1:0]  quo_q, mag;
    logic [CNT_W-1:0]  rem_q, den_q;
    logic              neg_q;
    logic [STEP_W-1:0] step_q;
    logic [CNT_W:0]    rsh;
    logic [CNT_W+1:0]  diff;

    assign mag  = sum_in[ACC_W-1] ? (~sum_in + ACC_W'(1)) : sum_in;
    assign rsh  = {rem_q, quo_q[ACC_W-1]};
    assign diff = {1'b0, rsh} - {2'b00, den_q};

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_IDLE: if (start && cnt_in != '0) state_d = DIV_STEP;
            DIV_STEP: if (step_q == '0)          state_d = DIV_SIGN;
            DIV_SIGN:                            state_d = DIV_IDLE;
            default:                             state_d = DIV_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= DIV_IDLE;
        else     state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q    <= '0;
            rem_q    <= '0;
            den_q    <= '0;
            neg_q    <= 1'b0;
            step_q   <= '0;
            quot_out <= '0;
            quot_vld <= 1'b0;
        end else begin
            quot_vld <= 1'b0;
            unique case (state_q)
                DIV_IDLE: begin
                    if (start) begin
                        if (cnt_in == '0) begin
                            quot_out <= '0;
                            quot_vld <= 1'b1;
                        end else begin
                            quo_q  <= mag;
                            rem_q  <= '0;
                            den_q  <= cnt_in;
                            neg_q  <= sum_in[ACC_W-1];
                            step_q <= STEP_W'(ACC_W - 1);
                        end
                    end
                end
                DIV_STEP: begin
                    step_q <= step_q - STEP_W'(1);
                    if (!diff[CNT_W+1]) begin
                        rem_q <= diff[CNT_W-1:0];
                        quo_q <= {quo_q[ACC_W-2:0], 1'b1};
                    end else begin
                        rem_q <= rsh[CNT_W-1:0];
                        quo_q <= {quo_q[ACC_W-2:0], 1'b0};
                    end
                end
                DIV_SIGN: begin
                    quot_out <= neg_q ? (~quo_q + ACC_W'(1)) : quo_q;
                    quot_vld <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R6: input assumption, a new snapshot only arrives while idle
    p_start_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
        state_q != DIV_IDLE |-> !start);

    // R6: the partial remainder stays below the divisor
    p_rem_bound_r6: assert property (@(posedge clk) disable iff (rst)
        state_q == DIV_STEP |-> rem_q < den_q);

    // R7: empty snapshot gives zero in the next cycle
    p_zero_count_r7: assert property (@(posedge clk) disable iff (rst)
        state_q == DIV_IDLE && start && cnt_in == '0 |=> quot_vld && quot_out == '0);

    // R9: result pulses never last more than a cycle
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        quot_vld |=> !quot_vld);

endmodule

// File: rtl/accum_dump.sv
`timescale 1ns/1ps
module accum_dump #(
    parameter int DATA_W     = 8,
    parameter bit DUMP_FIRST = 1'b1,
    parameter bit AVERAGE    = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   sample_in,
    input  logic                acc_en,
    input  logic                dump_en,
    output logic [2*DATA_W-1:0] result,
    output logic                result_vld
);
    localparam int ACC_W = 2 * DATA_W;
    localparam int CNT_W = DATA_W + 1;

    logic [ACC_W-1:0] snap_sum;
    logic [CNT_W-1:0] snap_cnt;
    logic             snap_vld;

    accd_core #(
        .DATA_W    (DATA_W),
        .DUMP_FIRST(DUMP_FIRST)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .sample_in(sample_in),
        .acc_en   (acc_en),
        .dump_en  (dump_en),
        .snap_sum (snap_sum),
        .snap_cnt (snap_cnt),
        .snap_vld (snap_vld)
    );

    generate
        if (AVERAGE) begin : g_mean
            accd_divider #(
                .ACC_W(ACC_W),
                .CNT_W(CNT_W)
            ) u_div (
                .clk     (clk),
                .rst     (rst),
                .start   (snap_vld),
                .sum_in  (snap_sum),
                .cnt_in  (snap_cnt),
                .quot_out(result),
                .quot_vld(result_vld)
            );
        end else begin : g_sum
            assign result     = snap_sum;
            assign result_vld = snap_vld;

            // R7: an empty snapshot carries a zero total
            p_empty_sum_r7: assert property (@(posedge clk) disable iff (rst)
                snap_vld && snap_cnt == '0 |-> snap_sum == '0);
        end
    endgenerate

    // R10: reset leaves a zero, non-valid output
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> result == '0 && !result_vld);

endmodule

// File: tb/accum_dump_tb.sv
`timescale 1ns/1ps
module accum_dump_tb;
    localparam int DW    = 4;
    localparam int AW    = 2 * DW;
    localparam int WIN   = AW + 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] sample_in = '0;
    logic          acc_en = 1'b0;
    logic          dump_en = 1'b0;
    logic [AW-1:0] res [4];
    logic          vld [4];

    int n_vec = 0;
    int n_bad = 0;

    // model state: df = dump-first, af = accumulate-first
    int m_df = 0, c_df = 0, m_af = 0, c_af = 0;

    always #10 clk = ~clk;

    // 0: dump-first sum, 1: acc-first sum, 2: dump-first mean, 3: acc-first mean
    accum_dump #(.DATA_W(DW), .DUMP_FIRST(1'b1), .AVERAGE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .sample_in(sample_in), .acc_en(acc_en),
        .dump_en(dump_en), .result(res[0]), .result_vld(vld[0]));
    accum_dump #(.DATA_W(DW), .DUMP_FIRST(1'b0), .AVERAGE(1'b0)) u_dut_af (
        .clk(clk), .rst(rst), .sample_in(sample_in), .acc_en(acc_en),
        .dump_en(dump_en), .result(res[1]), .result_vld(vld[1]));
    accum_dump #(.DATA_W(DW), .DUMP_FIRST(1'b1), .AVERAGE(1'b1)) u_dut_dfm (
        .clk(clk), .rst(rst), .sample_in(sample_in), .acc_en(acc_en),
        .dump_en(dump_en), .result(res[2]), .result_vld(vld[2]));
    accum_dump #(.DATA_W(DW), .DUMP_FIRST(1'b0), .AVERAGE(1'b1)) u_dut_afm (
        .clk(clk), .rst(rst), .sample_in(sample_in), .acc_en(acc_en),
        .dump_en(dump_en), .result(res[3]), .result_vld(vld[3]));

    function automatic int sx(input int raw);
        int r;
        r = raw % 16;
        return (r >= 8) ? r - 16 : r;
    endfunction

    function automatic int mean(input int s, input int c);
        return (c == 0) ? 0 : s / c;
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_group(input int n, input int base, input int stp, input bit coincide);
        int v, e_df, ec_df, e_af, ec_af;
        int expv [4];
        int ecnt [4];
        int pulses [4];
        int lat [4];
        logic [AW-1:0] got [4];
        logic [AW-1:0] want;
        string tag;
        for (int i = 0; i < n; i++) begin
            v = sx(base + stp * i);
            @(negedge clk);
            acc_en = 1'b1; dump_en = 1'b0; sample_in = v[DW-1:0];
            m_df += v; c_df++; m_af += v; c_af++;
        end
        @(negedge clk);
        v = sx(base + 5);
        dump_en = 1'b1; acc_en = coincide; sample_in = v[DW-1:0];
        if (coincide) begin
            e_df = m_df; ec_df = c_df; m_df = v; c_df = 1;
            e_af = m_af + v; ec_af = c_af + 1; m_af = 0; c_af = 0;
        end else begin
            e_df = m_df; ec_df = c_df; m_df = 0; c_df = 0;
            e_af = m_af; ec_af = c_af; m_af = 0; c_af = 0;
        end
        expv[0] = e_df; ecnt[0] = ec_df;
        expv[1] = e_af; ecnt[1] = ec_af;
        expv[2] = mean(e_df, ec_df); ecnt[2] = ec_df;
        expv[3] = mean(e_af, ec_af); ecnt[3] = ec_af;
        for (int d = 0; d < 4; d++) begin
            pulses[d] = 0; lat[d] = 0; got[d] = '0;
        end
        for (int k = 1; k <= WIN; k++) begin
            @(negedge clk);
            if (k == 1) begin acc_en = 1'b0; dump_en = 1'b0; end
            for (int d = 0; d < 4; d++) begin
                if (vld[d]) begin
                    pulses[d]++; lat[d] = k; got[d] = res[d];
                end
            end
        end
        for (int d = 0; d < 4; d++) begin
            want = expv[d][AW-1:0];
            if (ecnt[d] == 0)          tag = "R7 R3";
            else if (n == 16)          tag = "R8";
            else if (d >= 2)           tag = "R6";
            else if (coincide)         tag = (d == 0) ? "R4" : "R5";
            else                       tag = "R1 R2";
            chk(pulses[d] == 1, "R9 pulse count", pulses[d], 1);
            chk(got[d] == want, tag, int'(got[d]), int'(want));
            if (d < 2) chk(lat[d] == 1, "R2 latency", lat[d], 1);
            else       chk(lat[d] >= 1 && lat[d] <= AW + 3, "R6 latency", lat[d], AW + 3);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: state straight out of reset
        for (int d = 0; d < 4; d++) begin
            chk(res[d] == '0, "R10 reset result", int'(res[d]), 0);
            chk(vld[d] == 1'b0, "R10 reset valid", int'(vld[d]), 0);
        end
        rst = 1'b0;
        for (int n = 0; n <= 5; n++)
            for (int co = 0; co <= 1; co++)
                for (int b = 0; b < 16; b++)
                    run_group(n, b, 3, co[0]);
        // R8: full-length runs at both extremes
        run_group(0, 0, 0, 1'b0);
        run_group(16, 8, 0, 1'b0);
        run_group(16, 7, 0, 1'b0);
        // R10: reset in the middle of a group
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            acc_en = 1'b1; sample_in = 4'd5;
        end
        @(negedge clk);
        acc_en = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        for (int d = 0; d < 4; d++) begin
            chk(res[d] == '0 && vld[d] == 1'b0, "R10 mid reset", int'(res[d]), 0);
        end
        rst = 1'b0;
        m_df = 0; c_df = 0; m_af = 0; c_af = 0;
        run_group(0, 0, 0, 1'b0);
        summary();
        $finish;
    end

endmodule